// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. It accepts one read or write request at a time through a valid/ready handshake. For each request it sequences the memory's strobes: a low-active chip select, a high-active chip select, a low-active output enable and a low-active write enable. It also drives the shared byte-wide data bus through separate outgoing data, incoming data and driver-enable signals.

Every phase length is a whole number of clock cycles. These counts are derived when the design is elaborated from the clock period parameter and the memory's speed grade parameter (55 ns or 70 ns). Each count is the smallest number of cycles that covers the relevant nanosecond minimum.

The controller has seven named states. IDLE waits for a request. A read moves IDLE -> RD_ACC -> RD_REC -> IDLE. A write moves IDLE -> WR_GAP -> WR_DRV -> WR_END -> WR_REC -> IDLE.
- IDLE leaves on an accepted request, to RD_ACC or WR_GAP according to the write flag.
- RD_ACC ends when its access count is done and the read byte has been captured.
- RD_REC keeps the device deselected while the memory releases the bus.
- WR_GAP lowers the write strobe with the bus driver still off.
- WR_DRV turns the driver on with the write data.
- WR_END raises the write strobe while the data is still driven.
- WR_REC deselects the device with the driver off.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the memory sits in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dout_en`=0.
- R2: During a read, the device is selected with `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles, where RD_CYC = max(ceil(tAA/T), ceil(tOE/T)) + 1. This is 7 cycles at a 10 ns clock and the 55 ns grade.
- R3: The byte on `mem_din` during the last RD_ACC cycle appears on `rd_data`, with `rd_valid` high for exactly one cycle. That cycle is the first cycle after `mem_oe_n` returns high.
- R4: During a write, `mem_oe_n` stays high and `mem_we_n` is low for TURN + DRV cycles. This is 6 cycles at a 10 ns clock and the 55 ns grade, which covers the write pulse width, the data setup time and the address-valid-to-end-of-write time.
- R5: The first TURN write-strobe cycles (3 at 10 ns, 55 ns grade) keep `mem_dout_en` low. `mem_dout_en` and a low `mem_oe_n` never coincide.
- R6: `mem_dout_en` is still high, carrying `req_wdata`, on the cycle in which `mem_we_n` rises. The memory therefore stores the request's byte at the request's address.
- R7: `mem_addr` holds the accepted address, unchanged, from acceptance until `req_ready` returns high.
- R8: `req_ready` stays low for the full cycle count after each acceptance: 9 cycles for a read and 8 for a write at 10 ns and the 55 ns grade. This is never less than ceil(tRC/T).
- R9: `req_valid` while `req_ready` is low is ignored. It does not change the address, the strobes or the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` valid |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Low-active chip select |
| mem_ce2 | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_we_n | output | 1 | Low-active write enable |
| mem_dout | output | 8 | Byte driven toward the memory |
| mem_din | input | 8 | Byte sampled from the memory |
| mem_dout_en | output | 1 | Enables the controller's bus driver |

## Verification
The assertions assume a host that changes `req_valid`, `req_write`, `req_addr` and `req_wdata` only between clock edges. They also assume that `mem_din` is settled by the final RD_ACC edge. The bench's memory model updates `mem_din` on the falling clock edge and returns a byte only while the device is selected for a read. The model stores a byte when it sees the write strobe rise with the device selected. Requests are issued only while `req_ready` is high, except in the interference test, where `req_valid` is raised mid-transaction and lowered before the controller becomes ready.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_REC,
        ST_WR_GAP,
        ST_WR_DRV,
        ST_WR_END,
        ST_WR_REC
    } ctl_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R8
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= take;
            if (take) begin
                dout <= din;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int AW          = 17,
    parameter int DW          = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_NS    = 55
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dout,
    input  logic [DW-1:0] mem_din,
    output logic          mem_dout_en
);

    // Nanosecond minimums for the selected grade
    localparam bit SLOW   = (SPEED_NS > 55);
    localparam int T_RC   = SPEED_NS;
    localparam int T_AA   = SPEED_NS;
    localparam int T_OE   = SLOW ? 35 : 30;
    localparam int T_OHZ  = SLOW ? 25 : 20;
    localparam int T_WZ   = SLOW ? 30 : 25;
    localparam int T_WP   = SLOW ? 50 : 40;
    localparam int T_DW   = SLOW ? 30 : 25;
    localparam int T_AW   = SLOW ? 60 : 50;

    // Cycle counts
    localparam int P      = CLK_PERIOD_NS;
    localparam int C_CYC  = cdiv(T_RC, P);
    localparam int RD_CYC = imax(cdiv(T_AA, P), cdiv(T_OE, P)) + 1;
    localparam int REC_RD = imax(imax(cdiv(T_OHZ, P), C_CYC - RD_CYC), 1);
    localparam int TURN   = imax(imax(cdiv(T_WZ, P), cdiv(T_OHZ, P)), 1);
    localparam int DRV    = imax(imax(cdiv(T_DW, P), cdiv(T_WP, P) - TURN),
                                 imax(cdiv(T_AW, P) - TURN, 1));
    localparam int REC_WR = imax(C_CYC - (TURN + DRV + 1), 1);
    localparam int MAX_LD = imax(imax(RD_CYC, REC_RD), imax(imax(TURN, DRV), REC_WR));
    localparam int CW     = imax($clog2(MAX_LD + 1), 1);

    ctl_state_e      state_q, state_d;
    logic            t_load;
    logic [CW-1:0]   t_val;
    logic            t_done;
    logic            take;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;

    sram_phase_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Transitions and timer loads
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    t_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_GAP;
                        t_val   = CW'(TURN - 1);
                    end else begin
                        state_d = ST_RD_ACC;
                        t_val   = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (t_done) begin
                    state_d = ST_RD_REC;
                    t_load  = 1'b1;
                    t_val   = CW'(REC_RD - 1);
                end
            end
            ST_RD_REC: begin
                if (t_done) state_d = ST_IDLE;
            end
            ST_WR_GAP: begin
                if (t_done) begin
                    state_d = ST_WR_DRV;
                    t_load  = 1'b1;
                    t_val   = CW'(DRV - 1);
                end
            end
            ST_WR_DRV: begin
                if (t_done) state_d = ST_WR_END;
            end
            ST_WR_END: begin
                state_d = ST_WR_REC;
                t_load  = 1'b1;
                t_val   = CW'(REC_WR - 1);
            end
            ST_WR_REC: begin
                if (t_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe decode
    always_comb begin
        mem_ce1_n   = 1'b1;
        mem_ce2     = 1'b0;
        mem_oe_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_dout_en = 1'b0;
        req_ready   = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_RD_ACC: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_oe_n  = 1'b0;
            end
            ST_RD_REC: ;
            ST_WR_GAP: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_we_n  = 1'b0;
            end
            ST_WR_DRV: begin
                mem_ce1_n   = 1'b0;
                mem_ce2     = 1'b1;
                mem_we_n    = 1'b0;
                mem_dout_en = 1'b1;
            end
            ST_WR_END: begin
                mem_ce1_n   = 1'b0;
                mem_ce2     = 1'b1;
                mem_dout_en = 1'b1;
            end
            ST_WR_REC: ;
            default: ;
        endcase
    end

    assign take     = (state_q == ST_RD_ACC) && t_done;
    assign mem_addr = addr_q;
    assign mem_dout = wdata_q;

    sram_rd_capture #(.DW(DW)) cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .din   (mem_din),
        .dout  (rd_data),
        .valid (rd_valid)
    );

    // R1
    standby_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dout_en));

    // R3
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R4
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R5
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_oe_n));

    // R6
    drv_at_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dout_en);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mem_addr));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

    localparam int CLK_NS  = 10;
    localparam int EXP_OE  = 7;
    localparam int EXP_WE  = 6;
    localparam int EXP_GAP = 3;
    localparam int EXP_BRD = 9;
    localparam int EXP_BWR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dout_en;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;

    logic [7:0] model_mem [int];
    logic [7:0] ref_mem [int];
    logic [7:0] exp_q [$];

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    function automatic logic [7:0] fill(input logic [16:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model
    logic prev_we_m = 1'b1;
    always @(negedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !prev_we_m && mem_we_n)
            model_mem[int'(mem_addr)] = mem_dout;
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
            mem_din <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)]
                                                         : fill(mem_addr);
        else
            mem_din <= 8'h00;
        prev_we_m = mem_we_n;
    end

    // Monitor
    int we_lo = 0, gap = 0, wr_oe = 0, oe_lo = 0, busy = 0, addr_err = 0, fights = 0;
    bit saw_wr = 0, prev_we = 1, prev_oe = 1, prev_rdv = 0, prev_rdy = 1, prev_sel = 0;
    logic [16:0] prev_addr = '0;
    always @(negedge clk) begin
        if (started) begin
            if (mem_dout_en && !mem_oe_n) fights++;
            if (!mem_we_n) begin
                we_lo++;
                if (!mem_dout_en && we_lo == gap + 1) gap++;
                if (!mem_oe_n) wr_oe++;
            end
            if (!prev_we && mem_we_n) begin
                chk(we_lo == EXP_WE, "R4", "write strobe length", we_lo, EXP_WE);
                chk(wr_oe == 0, "R4", "oe low during write", wr_oe, 0);
                chk(gap == EXP_GAP, "R5", "turnaround cycles", gap, EXP_GAP);
                chk(mem_dout_en && !mem_ce1_n && mem_ce2, "R6", "driver at we rise",
                    mem_dout_en, 1);
                we_lo = 0; gap = 0; wr_oe = 0;
            end
            if (!mem_oe_n) oe_lo++;
            if (!prev_oe && mem_oe_n) begin
                chk(oe_lo == EXP_OE, "R2", "read strobe length", oe_lo, EXP_OE);
                chk(rd_valid, "R3", "rd_valid timing", rd_valid, 1);
                oe_lo = 0;
            end
            if (rd_valid) begin
                chk(!prev_rdv, "R3", "single valid pulse", prev_rdv, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected read data", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R3", "read data", rd_data, e);
                end
            end
            if (prev_sel && !mem_ce1_n && mem_addr != prev_addr) addr_err++;
            if (!req_ready) begin
                busy++;
                if (!mem_we_n) saw_wr = 1;
            end
            if (req_ready && !prev_rdy) begin
                chk(busy == (saw_wr ? EXP_BWR : EXP_BRD), "R8", "busy length",
                    busy, saw_wr ? EXP_BWR : EXP_BRD);
                chk(addr_err == 0, "R7", "address stability", addr_err, 0);
                chk(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dout_en,
                    "R1", "standby when ready", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n},
                    4'b1011);
                busy = 0; saw_wr = 0; addr_err = 0;
            end
        end
        prev_we = mem_we_n; prev_oe = mem_oe_n; prev_rdv = rd_valid;
        prev_rdy = req_ready; prev_sel = !mem_ce1_n; prev_addr = mem_addr;
    end

    // Driver
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) ref_mem[int'(a)] = d;
        else exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill(a));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dout_en && !rd_valid,
            "R1", "reset outputs", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
        started = 1'b1;

        issue(1, 17'h00ABC, 8'h3C);
        issue(0, 17'h00ABC, 8'h00);
        issue(1, 17'h1FFFF, 8'hFF);
        issue(0, 17'h1FFFF, 8'h00);
        issue(1, 17'h00000, 8'h00);
        issue(0, 17'h00000, 8'h00);
        issue(0, 17'h12345, 8'h00);
        issue(1, 17'h00010, 8'hA5);
        issue(1, 17'h00011, 8'h5A);
        issue(0, 17'h00010, 8'h00);
        issue(0, 17'h00011, 8'h00);

        // R9 interference during a busy read
        issue(0, 17'h00ABC, 8'h00);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0BEEF; req_wdata = 8'h11;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(mem_addr == 17'h00ABC && mem_we_n, "R9", "busy request ignored",
                mem_addr, 17'h00ABC);
        end
        req_valid = 1'b0;
        issue(0, 17'h0BEEF, 8'h00);

        for (int i = 0; i < 6; i++) issue(1, 17'(17'h02000 + i * 37), 8'(i * 29 + 3));
        for (int i = 5; i >= 0; i--) issue(0, 17'(17'h02000 + i * 37), 8'h00);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all reads returned", exp_q.size(), 0);
        chk(fights == 0, "R5", "bus contention cycles", fights, 0);
        summary();
        $finish;
    end

endmodule